// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block erases a contiguous run of flash erase blocks on behalf of a host. The host hands over a start byte address and a byte length on a valid/ready request port. The block screens the request against the erase-block grain and the device size, then reads the device status to confirm that writes are allowed. For each block it then reads the bad-block marker from the spare area of the block's first page, issues the two-phase erase and hands the wait to an external completion waiter. The run stops at the first protected, bad or failing block.

The block does not drive flash pins. Commands go out on a valid/ready command port to a command/address sequencer, which turns each beat into bus cycles. A command beat is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_valid` is high and `cmd_ready` is low, every command field is held stable. The sequencer returns exactly one `rsp_valid` beat for each status read or spare read it accepted. The block sits waiting for that beat and never back-pressures it. The request port is ready only while the block is idle. `req_start` and `req_len` are taken on the accepting edge.

Each run ends with a one-cycle `done` pulse. `result` gives the outcome, and `fail_page` names the page of the block that caused a failure.

Top module: `nand_erase_seq`

## Requirements
- R1: A request whose start address or length has any bit set under the erase-block mask (2^ERASE_SHIFT-1) is rejected. `done` pulses on the cycle after acceptance with `result` = 2'b10, and no command is issued.
- R2: A request whose start plus length exceeds DEV_SIZE is rejected in the same way. A run that ends exactly at DEV_SIZE is accepted.
- R3: The first command of an accepted run is a status read (code 0x70, no column, no page). If bit 7 of the returned byte is 0, the run fails with `result` = 2'b01, `fail_page` = start page, and no erase is issued.
- R4: Before each erase the block issues a spare read (code 0x50) with the column set to BB_COL (default 5) and the page set to the block's first page. Any returned byte other than 0xFF fails the run, with `fail_page` set to that page and the block left unerased.
- R5: An erase is a setup beat (code 0x60) carrying only the page address, then a confirm beat (code 0xD0) with no address. After that, `wait_start` pulses for one cycle.
- R6: A completion that is not interrupted and has `wait_fail` = 1 ends the run with `result` = 2'b01, and `fail_page` is the page of the block just erased.
- R7: After each good erase, the page address advances by 2^(ERASE_SHIFT-PAGE_SHIFT) and the remaining length falls by 2^ERASE_SHIFT. When the remaining length reaches 0, the run ends with `result` = 2'b00. A zero length ends with 2'b00 right after a passing status read.
- R8: A completion with `wait_intr` = 1 re-issues the erase of the same block, without advancing or counting it.
- R9: `done` is high for exactly one cycle per request. `req_ready` is high only while idle, and no command or wait start is driven while idle.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and all command fields stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Block is idle and takes the request |
| req_start | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W | Length in bytes |
| cmd_valid | output | 1 | Command beat offered to the sequencer |
| cmd_ready | input | 1 | Sequencer takes the beat |
| cmd_code | output | 8 | Command opcode |
| cmd_col_en | output | 1 | Beat carries a column address |
| cmd_col | output | 8 | Column address |
| cmd_page_en | output | 1 | Beat carries a page address |
| cmd_page | output | ADDR_W-PAGE_SHIFT | Page address |
| rsp_valid | input | 1 | Read byte returned for a status or spare read |
| rsp_data | input | 8 | Returned byte |
| wait_start | output | 1 | Start the erase completion waiter |
| wait_done | input | 1 | Waiter finished |
| wait_intr | input | 1 | Wait was interrupted; erase must be redone |
| wait_fail | input | 1 | Status bit 0 seen by the waiter |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 00 done, 01 failed, 10 rejected |
| fail_page | output | ADDR_W-PAGE_SHIFT | Page of the block that failed |

## Verification
The bench builds the block with 12-bit addresses, 4-byte pages, 16-byte erase blocks (four pages each) and a 256-byte device. With these values, a run that ends exactly at the last block and one that runs one block past it are only a few addresses apart. Multi-block runs also finish in tens of cycles, so bad-block stops, erase failures, interrupted waits and a stalling sequencer can each be placed at a chosen block. The bench's sequencer model checks every page it is handed against the page expected from the start address and the count of good erases. This makes a wrong stride or a skipped retry visible even when the final result happens to be right.

// File: rtl/nand_erase_pkg.sv
package nand_erase_pkg;
  localparam logic [7:0] OP_STATUS      = 8'h70;
  localparam logic [7:0] OP_READ_SPARE  = 8'h50;
  localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
  localparam logic [7:0] OP_ERASE_GO    = 8'hD0;

  typedef enum logic [1:0] {
    RES_DONE   = 2'b00,
    RES_FAIL   = 2'b01,
    RES_REJECT = 2'b10
  } res_e;
endpackage

// File: rtl/erase_req_check.sv
module erase_req_check #(
  parameter int ADDR_W      = 28,
  parameter int ERASE_SHIFT = 14,
  parameter int DEV_SIZE    = 1 << 26
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] len,
  output logic              ok
);
  localparam logic [ADDR_W-1:0] BLK_MASK = ADDR_W'((64'd1 << ERASE_SHIFT) - 64'd1);
  localparam logic [ADDR_W:0]   DEV_LIM  = (ADDR_W+1)'(DEV_SIZE);

  logic            misaligned;
  logic [ADDR_W:0] end_addr;

  always_comb begin
    misaligned = (|(start & BLK_MASK)) | (|(len & BLK_MASK));
    end_addr   = {1'b0, start} + {1'b0, len};
    ok         = !misaligned && (end_addr <= DEV_LIM);
  end
endmodule

// File: rtl/erase_block_walker.sv
module erase_block_walker #(
  parameter int ADDR_W      = 28,
  parameter int PAGE_SHIFT  = 9,
  parameter int ERASE_SHIFT = 14
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] start_page,
  input  logic [ADDR_W-1:0]            len,
  input  logic                         step,
  output logic [ADDR_W-PAGE_SHIFT-1:0] page,
  output logic                         rem_zero
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam logic [PAGE_W-1:0] PPB       = PAGE_W'(64'd1 << (ERASE_SHIFT - PAGE_SHIFT));
  localparam logic [ADDR_W-1:0] BLK_BYTES = ADDR_W'(64'd1 << ERASE_SHIFT);

  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] rem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      rem_q  <= '0;
    end else if (load) begin
      page_q <= start_page;
      rem_q  <= len;
    end else if (step) begin
      page_q <= page_q + PPB;
      rem_q  <= rem_q - BLK_BYTES;
    end
  end

  assign page     = page_q;
  assign rem_zero = (rem_q == '0);

  AST_STEP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> page_q == $past(page_q) + PPB); // R7
endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import nand_erase_pkg::*;
#(
  parameter int PAGE_W = 19,
  parameter int BB_COL = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ok,
  output logic              ld,
  output logic              step,
  input  logic [PAGE_W-1:0] page,
  input  logic              rem_zero,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_code,
  output logic              cmd_col_en,
  output logic [7:0]        cmd_col,
  output logic              cmd_page_en,
  output logic [PAGE_W-1:0] cmd_page,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic              wait_start,
  input  logic              wait_done,
  input  logic              wait_intr,
  input  logic              wait_fail,
  output logic              done,
  output logic [1:0]        result,
  output logic [PAGE_W-1:0] fail_page
);
  typedef enum logic [3:0] {
    S_IDLE, S_WP_CMD, S_WP_RSP, S_NEXT, S_BB_CMD, S_BB_RSP,
    S_ER_SETUP, S_ER_GO, S_WAIT_GO, S_WAIT
  } st_e;

  st_e  st_q;
  logic fin;
  res_e fin_res;
  logic fin_rec_page;

  assign req_ready  = (st_q == S_IDLE);
  assign wait_start = (st_q == S_WAIT_GO);
  assign cmd_valid  = (st_q == S_WP_CMD) || (st_q == S_BB_CMD) ||
                      (st_q == S_ER_SETUP) || (st_q == S_ER_GO);
  assign cmd_page   = page;

  always_comb begin
    cmd_code    = OP_STATUS;
    cmd_col_en  = 1'b0;
    cmd_col     = '0;
    cmd_page_en = 1'b0;
    unique case (st_q)
      S_BB_CMD: begin
        cmd_code    = OP_READ_SPARE;
        cmd_col_en  = 1'b1;
        cmd_col     = 8'(BB_COL);
        cmd_page_en = 1'b1;
      end
      S_ER_SETUP: begin
        cmd_code    = OP_ERASE_SETUP;
        cmd_page_en = 1'b1;
      end
      S_ER_GO:  cmd_code = OP_ERASE_GO;
      default:  cmd_code = OP_STATUS;
    endcase
  end

  always_comb begin
    ld           = 1'b0;
    step         = 1'b0;
    fin          = 1'b0;
    fin_res      = RES_DONE;
    fin_rec_page = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        if (req_ok) ld = 1'b1;
        else begin
          fin     = 1'b1;
          fin_res = RES_REJECT;
        end
      end
      S_WP_RSP: if (rsp_valid && !rsp_data[7]) begin
        fin          = 1'b1;
        fin_res      = RES_FAIL;
        fin_rec_page = 1'b1;
      end
      S_NEXT: if (rem_zero) fin = 1'b1;
      S_BB_RSP: if (rsp_valid && rsp_data != 8'hFF) begin
        fin          = 1'b1;
        fin_res      = RES_FAIL;
        fin_rec_page = 1'b1;
      end
      S_WAIT: if (wait_done && !wait_intr) begin
        if (wait_fail) begin
          fin          = 1'b1;
          fin_res      = RES_FAIL;
          fin_rec_page = 1'b1;
        end else step = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      done      <= 1'b0;
      result    <= RES_DONE;
      fail_page <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        result <= fin_res;
        st_q   <= S_IDLE;
        if (fin_rec_page) fail_page <= page;
      end else begin
        case (st_q)
          S_IDLE:     if (req_valid) st_q <= S_WP_CMD;
          S_WP_CMD:   if (cmd_ready) st_q <= S_WP_RSP;
          S_WP_RSP:   if (rsp_valid) st_q <= S_NEXT;
          S_NEXT:     st_q <= S_BB_CMD;
          S_BB_CMD:   if (cmd_ready) st_q <= S_BB_RSP;
          S_BB_RSP:   if (rsp_valid) st_q <= S_ER_SETUP;
          S_ER_SETUP: if (cmd_ready) st_q <= S_ER_GO;
          S_ER_GO:    if (cmd_ready) st_q <= S_WAIT_GO;
          S_WAIT_GO:  st_q <= S_WAIT;
          S_WAIT: if (wait_done) st_q <= wait_intr ? S_ER_SETUP : S_NEXT;
          default:    st_q <= S_IDLE;
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !wait_start); // R9
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_page)
      && $stable(cmd_col_en) && $stable(cmd_page_en)); // R10
  AST_SETUP_PAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == OP_ERASE_SETUP |-> cmd_page_en && !cmd_col_en); // R5
  AST_GO_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == OP_ERASE_GO |-> !cmd_page_en && !cmd_col_en); // R5
  AST_WAIT_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
    wait_start |-> $past(cmd_valid && cmd_ready && cmd_code == OP_ERASE_GO)); // R5
endmodule

// File: rtl/nand_erase_seq.sv
module nand_erase_seq
  import nand_erase_pkg::*;
#(
  parameter int ADDR_W      = 28,
  parameter int PAGE_SHIFT  = 9,
  parameter int ERASE_SHIFT = 14,
  parameter int DEV_SIZE    = 1 << 26,
  parameter int BB_COL      = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [ADDR_W-1:0]            req_start,
  input  logic [ADDR_W-1:0]            req_len,
  output logic                         cmd_valid,
  input  logic                         cmd_ready,
  output logic [7:0]                   cmd_code,
  output logic                         cmd_col_en,
  output logic [7:0]                   cmd_col,
  output logic                         cmd_page_en,
  output logic [ADDR_W-PAGE_SHIFT-1:0] cmd_page,
  input  logic                         rsp_valid,
  input  logic [7:0]                   rsp_data,
  output logic                         wait_start,
  input  logic                         wait_done,
  input  logic                         wait_intr,
  input  logic                         wait_fail,
  output logic                         done,
  output logic [1:0]                   result,
  output logic [ADDR_W-PAGE_SHIFT-1:0] fail_page
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic              req_ok;
  logic              ld;
  logic              step;
  logic              rem_zero;
  logic [PAGE_W-1:0] page;

  erase_req_check #(
    .ADDR_W(ADDR_W), .ERASE_SHIFT(ERASE_SHIFT), .DEV_SIZE(DEV_SIZE)
  ) u_check (
    .start(req_start), .len(req_len), .ok(req_ok)
  );

  erase_block_walker #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ERASE_SHIFT(ERASE_SHIFT)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .load(ld),
    .start_page(req_start[ADDR_W-1:PAGE_SHIFT]), .len(req_len),
    .step(step), .page(page), .rem_zero(rem_zero)
  );

  erase_seq_ctrl #(
    .PAGE_W(PAGE_W), .BB_COL(BB_COL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_ok(req_ok),
    .ld(ld), .step(step), .page(page), .rem_zero(rem_zero),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_col_en(cmd_col_en), .cmd_col(cmd_col), .cmd_page_en(cmd_page_en),
    .cmd_page(cmd_page), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wait_start(wait_start), .wait_done(wait_done), .wait_intr(wait_intr),
    .wait_fail(wait_fail), .done(done), .result(result), .fail_page(fail_page)
  );

  AST_REJECT_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_ok |=> done && result == RES_REJECT); // R1
  AST_ACCEPT_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_ok |=> cmd_valid && cmd_code == OP_STATUS); // R3
endmodule

// File: tb/nand_erase_seq_test.sv
module nand_erase_seq_test;
  localparam int ADDR_W = 12, PAGE_SHIFT = 2, ERASE_SHIFT = 4, DEV_SIZE = 256;
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int PPB = 4;

  typedef struct packed {
    logic [11:0] start;
    logic [11:0] len;
    logic        wp;
    logic [7:0]  bad;
    logic [7:0]  efail;
    logic [7:0]  intr;
    logic        stall;
    logic [1:0]  res;
    logic [9:0]  fpage;
    logic [7:0]  erases;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{12'd0,   12'd48, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 2'b00, 10'd0,  8'd3}, // R7
    '{12'd32,  12'd64, 1'b0, 8'd4,  8'hFF, 8'hFF, 1'b0, 2'b01, 10'd16, 8'd2}, // R4
    '{12'd16,  12'd32, 1'b0, 8'hFF, 8'd2,  8'hFF, 1'b0, 2'b01, 10'd8,  8'd2}, // R6
    '{12'd0,   12'd16, 1'b1, 8'hFF, 8'hFF, 8'hFF, 1'b0, 2'b01, 10'd0,  8'd0}, // R3
    '{12'd8,   12'd16, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 2'b10, 10'd0,  8'd0}, // R1
    '{12'd16,  12'd20, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 2'b10, 10'd0,  8'd0}, // R1
    '{12'd240, 12'd32, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 2'b10, 10'd0,  8'd0}, // R2
    '{12'd224, 12'd32, 1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 2'b00, 10'd0,  8'd2}, // R2
    '{12'd16,  12'd32, 1'b0, 8'hFF, 8'hFF, 8'd1,  1'b0, 2'b00, 10'd0,  8'd2}, // R8
    '{12'd0,   12'd0,  1'b0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 2'b00, 10'd0,  8'd0}, // R7
    '{12'd64,  12'd48, 1'b0, 8'd5,  8'hFF, 8'hFF, 1'b1, 2'b01, 10'd20, 8'd1}  // R10
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [ADDR_W-1:0] req_start = '0, req_len = '0;
  logic              cmd_valid, cmd_ready = 1'b1, cmd_col_en, cmd_page_en;
  logic [7:0]        cmd_code, cmd_col;
  logic [PAGE_W-1:0] cmd_page, fail_page;
  logic              rsp_valid = 1'b0;
  logic [7:0]        rsp_data = '0;
  logic              wait_start, wait_done = 1'b0, wait_intr = 1'b0, wait_fail = 1'b0;
  logic              done;
  logic [1:0]        result;

  nand_erase_seq #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .ERASE_SHIFT(ERASE_SHIFT),
                   .DEV_SIZE(DEV_SIZE), .BB_COL(5)) uut (.*);

  int checks = 0, fails = 0;
  // sequencer and waiter model state
  vec_t cur;
  int   ncmd, oks, proto, rsp_pend, wcnt, intr_used, stall_ph;
  logic [7:0] pend_byte;
  logic [PAGE_W-1:0] er_page;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rsp_valid) rsp_valid = 1'b0;
    if (rsp_pend) begin rsp_valid = 1'b1; rsp_data = pend_byte; rsp_pend = 0; end
    wait_done = 1'b0; wait_intr = 1'b0; wait_fail = 1'b0;
    if (wcnt > 0) begin
      wcnt--;
      if (wcnt == 0) begin
        wait_done = 1'b1;
        if (cur.intr != 8'hFF && int'(er_page) / PPB == int'(cur.intr) && !intr_used) begin
          wait_intr = 1'b1; intr_used = 1;
        end else begin
          oks++;
          wait_fail = (int'(er_page) / PPB == int'(cur.efail));
        end
      end
    end
    if (wait_start) wcnt = 3;
    stall_ph++;
    cmd_ready = cur.stall ? stall_ph[1] : 1'b1;
    if (cmd_valid && cmd_ready) begin
      ncmd++;
      case (cmd_code)
        8'h70: begin
          if (cmd_col_en || cmd_page_en) proto++;
          pend_byte = cur.wp ? 8'h00 : 8'hC0; rsp_pend = 1;
        end
        8'h50: begin
          if (!cmd_col_en || cmd_col != 8'd5 || !cmd_page_en) proto++;
          if (int'(cmd_page) != int'(cur.start) / 4 + oks * PPB) proto++;
          pend_byte = (int'(cmd_page) / PPB == int'(cur.bad)) ? 8'h00 : 8'hFF; rsp_pend = 1;
        end
        8'h60: begin
          if (cmd_col_en || !cmd_page_en) proto++;
          if (int'(cmd_page) != int'(cur.start) / 4 + oks * PPB) proto++;
          er_page = cmd_page;
        end
        8'hD0: if (cmd_col_en || cmd_page_en) proto++;
        default: proto++;
      endcase
    end
  end

  task automatic run_vec(input vec_t v, input int idx);
    int t;
    cur = v; ncmd = 0; oks = 0; proto = 0; intr_used = 0; stall_ph = 0;
    @(negedge clk);
    req_start = v.start; req_len = v.len; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 2000) begin @(negedge clk); t++; end
    chk($sformatf("R9 done seen vec%0d", idx), int'(done), 1);
    chk($sformatf("R1 R2 R3 R7 result vec%0d", idx), int'(result), int'(v.res));
    if (v.res == 2'b01)
      chk($sformatf("R4 R6 fail_page vec%0d", idx), int'(fail_page), int'(v.fpage));
    chk($sformatf("R7 R8 erase count vec%0d", idx), oks, int'(v.erases));
    chk($sformatf("R5 R10 command protocol vec%0d", idx), proto, 0);
    if (v.res == 2'b10) chk($sformatf("R1 no command vec%0d", idx), ncmd, 0);
    @(negedge clk);
    chk($sformatf("R9 done single cycle vec%0d", idx), int'(done), 0);
    chk($sformatf("R9 ready after run vec%0d", idx), int'(req_ready), 1);
  endtask

  initial begin
    cur = VECS[0]; ncmd = 0; oks = 0; proto = 0; rsp_pend = 0; wcnt = 0;
    intr_used = 0; stall_ph = 0; er_page = '0; pend_byte = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset done low", int'(done), 0);
    chk("R9 reset ready", int'(req_ready), 1);
    chk("R9 reset no cmd", int'(cmd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle no wait_start", int'(wait_start), 0);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
    // directed: interrupt on the last block with stalls, then erase failure on it
    run_vec('{12'd128, 12'd32, 1'b0, 8'hFF, 8'hFF, 8'd9, 1'b1, 2'b00, 10'd0, 8'd2}, 100); // R8
    run_vec('{12'd240, 12'd16, 1'b0, 8'hFF, 8'd15, 8'hFF, 1'b0, 2'b01, 10'd60, 8'd1}, 101); // R6
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule